// File: doc/BRIEF.md
# Segment Offset Limit and Access Checker

This block checks every memory access made through a loaded segment register. It takes the cached attributes of the descriptor behind that register: a 20-bit limit, a granularity flag, an expand-down flag, a default-size flag, the type bits and a null marker. It also takes the access offset, the access length, the access kind (read, write or instruction fetch), a 64-bit-mode flag and the identity of the segment register used. In the same cycle it answers with either a permit or a fault. A fault carries a two-bit cause and the identity of the segment register that caused it.

The block applies granularity scaling to the limit. It handles expand-down segments, whose valid window lies above the limit and is capped by a bound that depends on the default-size flag. It checks both the first and the last byte of a multi-byte access, and it treats any carry past the top of the offset space as a violation. In 64-bit mode the limit and null checks are suppressed, and only the type rules stay active. The block does not form the linear address and does not perform paging.

The block has no internal state. Its clock and reset serve only its embedded assertions.

Top module: `seg_access_checker`

## Requirements
- R1: With `desc_g`=0 the effective limit is the 20-bit limit zero-extended. With `desc_g`=1 the effective limit is the limit shifted left by 12 with the low 12 bits set to ones. For example, limit 0x00001 gives 0x1FFF.
- R2: For a segment with `desc_e`=0, both the first byte offset and the last byte offset (offset + `acc_len_m1`) must lie in the closed range from 0 to the effective limit. Otherwise the access faults with cause limit.
- R3: For a segment with `desc_e`=1, the first byte offset must be at least the effective limit, and the last byte offset must not exceed the upper bound. The upper bound is 0xFFFF when `desc_b`=0 and 0xFFFFFFFF when `desc_b`=1. A violation faults with cause limit.
- R4: If offset + `acc_len_m1` carries past 0xFFFFFFFF, the access is a limit violation for both normal and expand-down segments.
- R5: The type field has bit 3 = 1 for a code segment. Bit 1 means writable for a data segment and readable for a code segment. Bits 2 and 0 are ignored. A write (`acc_kind`=01) to a code segment faults with cause type, and so does a write to a data segment whose bit 1 is 0.
- R6: A read (`acc_kind`=00, or the unused code 11) from a code segment with bit 1 = 0 faults with cause type. A fetch (`acc_kind`=10) from a data segment faults with cause type. A fetch from any code segment passes the type check.
- R7: Outside 64-bit mode, an access whose descriptor has `desc_null`=1 faults with cause null, whatever its kind, offset or attributes.
- R8: With `mode64`=1, neither the limit check nor the null check is applied. The type rules of R5 and R6 still apply.
- R9: The cause codes are 00 none, 01 limit, 10 type and 11 null. When several checks fail, null takes priority over type, and type takes priority over limit.
- R10: The outputs follow the inputs combinationally in the same cycle. With `acc_valid`=0, all outputs are zero. `fault_seg` equals `seg_id` while `acc_fault` is high and is zero otherwise. `acc_ok` and `acc_fault` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded assertions |
| rst_n | input | 1 | Active-low reset for the embedded assertions |
| acc_valid | input | 1 | An access request is present |
| acc_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 treated as read |
| acc_offset | input | 32 | Offset of the first byte accessed |
| acc_len_m1 | input | 3 | Access length in bytes minus one |
| seg_id | input | 3 | Identity of the segment register used |
| mode64 | input | 1 | Processor is in 64-bit mode |
| desc_limit | input | 20 | Raw limit field of the cached descriptor |
| desc_g | input | 1 | Granularity flag |
| desc_e | input | 1 | Expand-down flag |
| desc_b | input | 1 | Default-size flag, selects the expand-down upper bound |
| desc_type | input | 4 | Descriptor type bits |
| desc_null | input | 1 | Segment register holds a null selector |
| acc_ok | output | 1 | Access permitted |
| acc_fault | output | 1 | Access faults |
| fault_cause | output | 2 | Cause code of the fault |
| fault_seg | output | 3 | Segment register identity of the faulting access |

## Verification
The assertions watch on every cycle the properties that hold for any input. An idle request must keep all outputs quiet. Permit and fault must stay mutually exclusive. The segment identity must be echoed on a fault. A null fault must appear outside 64-bit mode, and 64-bit mode must never report a limit or null cause. A write to a code segment must report a type fault unless a null fault outranks it. The exact boundaries need the bench's directed scenarios. These are the scaled limit edge, the first and last bytes of an expand-down window under both bounds, the carry past the top of the offset space, and the ordering between competing causes.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_FETCH = 2'b10,
        KIND_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_LIMIT = 2'b01,
        CAUSE_TYPE  = 2'b10,
        CAUSE_NULL  = 2'b11
    } fault_cause_e;

    typedef struct packed {
        logic         ok;
        logic         fault;
        fault_cause_e cause;
    } check_res_t;

    localparam int unsigned TYPE_CODE_BIT = 3;
    localparam int unsigned TYPE_RW_BIT   = 1;

endpackage

// File: rtl/seg_limit_scale.sv
module seg_limit_scale #(
    parameter int unsigned LIMIT_W    = 20,
    parameter int unsigned GRAN_SHIFT = 12,
    parameter int unsigned OFF_W      = 32
) (
    input  logic [LIMIT_W-1:0] raw_limit,
    input  logic               gran,
    output logic [OFF_W-1:0]   eff_limit
);
    localparam int unsigned SCALED_W = LIMIT_W + GRAN_SHIFT;

    logic [SCALED_W-1:0] scaled_d;
    logic [SCALED_W-1:0] plain_d;

    always_comb begin
        scaled_d = {raw_limit, {GRAN_SHIFT{1'b1}}};
        plain_d  = SCALED_W'(raw_limit);
        eff_limit = gran ? OFF_W'(scaled_d) : OFF_W'(plain_d);
    end
endmodule

// File: rtl/seg_range_check.sv
module seg_range_check #(
    parameter int unsigned OFF_W      = 32,
    parameter int unsigned LEN_W      = 3,
    parameter int unsigned SMALL_UB_W = 16
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [LEN_W-1:0] len_m1,
    input  logic [OFF_W-1:0] eff_limit,
    input  logic             expand_down,
    input  logic             big_bound,
    output logic             violation
);
    localparam int unsigned EXT_W = OFF_W + 1;

    logic [EXT_W-1:0] last_d;
    logic [EXT_W-1:0] limit_ext_d;
    logic [EXT_W-1:0] ubound_d;
    logic             normal_bad_d;
    logic             below_bad_d;
    logic             above_bad_d;

    always_comb begin
        last_d       = {1'b0, offset} + EXT_W'(len_m1);
        limit_ext_d  = {1'b0, eff_limit};
        ubound_d     = big_bound ? {1'b0, {OFF_W{1'b1}}}
                                 : EXT_W'({SMALL_UB_W{1'b1}});
        normal_bad_d = last_d > limit_ext_d;
        below_bad_d  = offset < eff_limit;
        above_bad_d  = last_d > ubound_d;
        violation    = expand_down ? (below_bad_d || above_bad_d) : normal_bad_d;
    end
endmodule

// File: rtl/seg_type_check.sv
module seg_type_check
    import seg_chk_pkg::*;
(
    input  acc_kind_e kind,
    input  logic      is_code,
    input  logic      rw_ok,
    output logic      violation
);
    always_comb begin
        unique case (kind)
            KIND_WRITE: violation = is_code || !rw_ok;
            KIND_FETCH: violation = !is_code;
            default:    violation = is_code && !rw_ok;
        endcase
    end
endmodule

// File: rtl/seg_access_checker.sv
module seg_access_checker
    import seg_chk_pkg::*;
#(
    parameter int unsigned LIMIT_W    = 20,
    parameter int unsigned GRAN_SHIFT = 12,
    parameter int unsigned OFF_W      = LIMIT_W + GRAN_SHIFT,
    parameter int unsigned LEN_W      = 3,
    parameter int unsigned SEG_W      = 3,
    parameter int unsigned SMALL_UB_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic [1:0]         acc_kind,
    input  logic [OFF_W-1:0]   acc_offset,
    input  logic [LEN_W-1:0]   acc_len_m1,
    input  logic [SEG_W-1:0]   seg_id,
    input  logic               mode64,
    input  logic [LIMIT_W-1:0] desc_limit,
    input  logic               desc_g,
    input  logic               desc_e,
    input  logic               desc_b,
    input  logic [3:0]         desc_type,
    input  logic               desc_null,
    output logic               acc_ok,
    output logic               acc_fault,
    output logic [1:0]         fault_cause,
    output logic [SEG_W-1:0]   fault_seg
);
    logic [OFF_W-1:0] eff_limit_d;
    logic             range_bad_d;
    logic             type_bad_d;
    logic             null_hit_d;
    logic             limit_hit_d;
    check_res_t       res_d;
    acc_kind_e        kind_d;
    logic             unused_type_bits;

    assign kind_d           = acc_kind_e'(acc_kind);
    assign unused_type_bits = ^{desc_type[2], desc_type[0]};

    seg_limit_scale #(
        .LIMIT_W   (LIMIT_W),
        .GRAN_SHIFT(GRAN_SHIFT),
        .OFF_W     (OFF_W)
    ) u_scale (
        .raw_limit(desc_limit),
        .gran     (desc_g),
        .eff_limit(eff_limit_d)
    );

    seg_range_check #(
        .OFF_W     (OFF_W),
        .LEN_W     (LEN_W),
        .SMALL_UB_W(SMALL_UB_W)
    ) u_range (
        .offset     (acc_offset),
        .len_m1     (acc_len_m1),
        .eff_limit  (eff_limit_d),
        .expand_down(desc_e),
        .big_bound  (desc_b),
        .violation  (range_bad_d)
    );

    seg_type_check u_type (
        .kind     (kind_d),
        .is_code  (desc_type[TYPE_CODE_BIT]),
        .rw_ok    (desc_type[TYPE_RW_BIT]),
        .violation(type_bad_d)
    );

    always_comb begin
        null_hit_d  = !mode64 && desc_null;
        limit_hit_d = !mode64 && range_bad_d;
        res_d       = '{ok: 1'b0, fault: 1'b0, cause: CAUSE_NONE};
        if (acc_valid) begin
            if (null_hit_d) begin
                res_d.fault = 1'b1;
                res_d.cause = CAUSE_NULL;
            end else if (type_bad_d) begin
                res_d.fault = 1'b1;
                res_d.cause = CAUSE_TYPE;
            end else if (limit_hit_d) begin
                res_d.fault = 1'b1;
                res_d.cause = CAUSE_LIMIT;
            end else begin
                res_d.ok = 1'b1;
            end
        end
        acc_ok      = res_d.ok;
        acc_fault   = res_d.fault;
        fault_cause = res_d.cause;
        fault_seg   = res_d.fault ? seg_id : '0;
    end

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!acc_ok && !acc_fault && fault_cause == 2'b00));

    p_ok_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok |-> (!acc_fault && fault_cause == 2'b00));

    p_seg_echo_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault |-> (fault_seg == seg_id));

    p_cause_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault |-> (fault_cause != 2'b00));

    p_null_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !mode64 && desc_null) |-> (acc_fault && fault_cause == 2'b11));

    p_no_limit_64_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && mode64) |-> (fault_cause != 2'b01 && fault_cause != 2'b11));

    p_code_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 2'b01 && desc_type[3] && !(desc_null && !mode64))
        |-> (acc_fault && fault_cause == 2'b10));
endmodule

// File: tb/seg_access_checker_test.sv
module seg_access_checker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid;
    logic [1:0]  acc_kind;
    logic [31:0] acc_offset;
    logic [2:0]  acc_len_m1;
    logic [2:0]  seg_id;
    logic        mode64;
    logic [19:0] desc_limit;
    logic        desc_g, desc_e, desc_b;
    logic [3:0]  desc_type;
    logic        desc_null;
    logic        acc_ok, acc_fault;
    logic [1:0]  fault_cause;
    logic [2:0]  fault_seg;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    seg_access_checker uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .acc_offset(acc_offset), .acc_len_m1(acc_len_m1), .seg_id(seg_id),
        .mode64(mode64), .desc_limit(desc_limit), .desc_g(desc_g),
        .desc_e(desc_e), .desc_b(desc_b), .desc_type(desc_type),
        .desc_null(desc_null), .acc_ok(acc_ok), .acc_fault(acc_fault),
        .fault_cause(fault_cause), .fault_seg(fault_seg)
    );

    task automatic base(input logic [3:0] ty);
        @(negedge clk);
        acc_valid = 1'b1; acc_kind = 2'b00; acc_offset = 32'h0; acc_len_m1 = 3'd0;
        seg_id = 3'd3; mode64 = 1'b0; desc_limit = 20'h0; desc_g = 1'b0;
        desc_e = 1'b0; desc_b = 1'b0; desc_type = ty; desc_null = 1'b0;
    endtask

    task automatic expect_res(input string tag, input logic [1:0] cause);
        logic       exp_ok, exp_fault;
        logic [2:0] exp_seg;
        #1;
        exp_ok    = acc_valid && (cause == 2'b00);
        exp_fault = acc_valid && (cause != 2'b00);
        exp_seg   = exp_fault ? seg_id : 3'd0;
        n_checks++;
        if (acc_ok !== exp_ok || acc_fault !== exp_fault ||
            fault_cause !== cause || fault_seg !== exp_seg) begin
            n_fail++;
            $display("FAIL %s: got ok=%b fault=%b cause=%b seg=%0d, expected ok=%b fault=%b cause=%b seg=%0d",
                     tag, acc_ok, acc_fault, fault_cause, fault_seg,
                     exp_ok, exp_fault, cause, exp_seg);
        end
    endtask

    task automatic t_idle;
        base(4'b0010); acc_valid = 1'b0; desc_null = 1'b1;
        expect_res("R10 idle quiet", 2'b00);
    endtask

    task automatic t_normal_gran;
        base(4'b0010); desc_limit = 20'h00010;
        acc_offset = 32'h10; expect_res("R2 last byte at limit", 2'b00);
        acc_len_m1 = 3'd1;   expect_res("R2 last byte past limit", 2'b01);
        desc_g = 1'b1; desc_limit = 20'h00001;
        acc_offset = 32'h1FFC; acc_len_m1 = 3'd3; expect_res("R1 scaled limit edge ok", 2'b00);
        acc_offset = 32'h1FFD; expect_res("R1 scaled limit edge +1", 2'b01);
        desc_g = 1'b0; acc_offset = 32'h1FFC; expect_res("R1 unscaled limit", 2'b01);
    endtask

    task automatic t_expand_down;
        base(4'b0110); desc_e = 1'b1; desc_limit = 20'h00100;
        acc_offset = 32'h100; expect_res("R3 at limit", 2'b00);
        acc_offset = 32'hFF;  expect_res("R3 below limit", 2'b01);
        acc_offset = 32'hFFFE; acc_len_m1 = 3'd1; expect_res("R3 small bound top", 2'b00);
        acc_offset = 32'hFFFF; expect_res("R3 small bound crossed", 2'b01);
        desc_b = 1'b1; expect_res("R3 big bound", 2'b00);
        acc_offset = 32'h12345; acc_len_m1 = 3'd3; expect_res("R3 big bound mid", 2'b00);
    endtask

    task automatic t_wrap;
        base(4'b0010); desc_g = 1'b1; desc_limit = 20'hFFFFF;
        acc_offset = 32'hFFFFFFFE; acc_len_m1 = 3'd1; expect_res("R4 top byte ok", 2'b00);
        acc_offset = 32'hFFFFFFFF; expect_res("R4 wrap normal", 2'b01);
        desc_e = 1'b1; desc_b = 1'b1; desc_g = 1'b0; desc_limit = 20'h0;
        acc_offset = 32'hFFFFFFFD; acc_len_m1 = 3'd3; expect_res("R4 wrap expand-down", 2'b01);
    endtask

    task automatic t_types;
        base(4'b1010); desc_limit = 20'hFFFFF;
        acc_kind = 2'b01; expect_res("R5 write code", 2'b10);
        desc_type = 4'b0101; expect_res("R5 write read-only data", 2'b10);
        desc_type = 4'b0010; expect_res("R5 write writable data", 2'b00);
        desc_type = 4'b1000; acc_kind = 2'b00; expect_res("R6 read exec-only code", 2'b10);
        acc_kind = 2'b11; expect_res("R6 reserved kind as read", 2'b10);
        acc_kind = 2'b10; expect_res("R6 fetch code", 2'b00);
        desc_type = 4'b1010; acc_kind = 2'b00; expect_res("R6 read readable code", 2'b00);
        desc_type = 4'b0010; acc_kind = 2'b10; expect_res("R6 fetch data", 2'b10);
    endtask

    task automatic t_null;
        base(4'b0010); desc_null = 1'b1; seg_id = 3'd5; desc_limit = 20'hFFFFF;
        expect_res("R7 null read", 2'b00 | 2'b11);
        acc_kind = 2'b10; expect_res("R7 null fetch", 2'b11);
    endtask

    task automatic t_mode64;
        base(4'b0010); mode64 = 1'b1; desc_limit = 20'h00001;
        acc_offset = 32'h8000_0000; expect_res("R8 no limit in 64", 2'b00);
        desc_null = 1'b1; expect_res("R8 no null in 64", 2'b00);
        desc_type = 4'b1010; acc_kind = 2'b01; expect_res("R8 type kept in 64", 2'b10);
    endtask

    task automatic t_priority;
        base(4'b1010); acc_kind = 2'b01; acc_offset = 32'h100; seg_id = 3'd6;
        expect_res("R9 type over limit", 2'b10);
        desc_null = 1'b1; expect_res("R9 null over type", 2'b11);
        desc_null = 1'b0; desc_type = 4'b0010; seg_id = 3'd1; expect_res("R9 limit alone", 2'b01);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        acc_valid = 1'b0; acc_kind = 2'b00; acc_offset = '0; acc_len_m1 = '0;
        seg_id = '0; mode64 = 1'b0; desc_limit = '0; desc_g = 1'b0; desc_e = 1'b0;
        desc_b = 1'b0; desc_type = '0; desc_null = 1'b0;
        repeat (3) @(posedge clk);
        #1 expect_res("R10 reset state", 2'b00);
        rst_n = 1'b1;
        t_idle;
        t_normal_gran;
        t_expand_down;
        t_wrap;
        t_types;
        t_null;
        t_mode64;
        t_priority;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule